// File: doc/BRIEF.md
# Vertical Half-Line Timer

This block keeps the vertical timing of a video output path. A horizontal line-end strobe comes in once per scan line. The block then steps a 10-bit half-line position within the current field. At the end of each field the position returns to the start of the next field. In interlaced operation the least significant bit of the position alternates from field to field, so it names the current field.

From that position the block drives three timing windows: vertical sync, vertical active video and colour-burst enable. It also raises a vertical interrupt when the position reaches a programmed half-line. Software programs the block through a small 32-bit register bus with a word index. The bus reads back every setting and the live position. Any write to the position register acknowledges the interrupt.

Register map (word index: contents): 0 control, where bits [1:0] hold the pixel type and bit 2 enables interlace. 1 interrupt half-line in bits [9:0]. 2 current position, where a read returns it and a write acknowledges the interrupt. 3 field length in half-lines, bits [9:0]. 4 timing, with the sync width in half-lines at bits [19:16]. 5 active window and 6 burst window, each with its first half-line in bits [25:16] and its end half-line in bits [9:0].

Top module: `vline_timer`

## Requirements
- R1: After reset the position is 0, the interrupt is low, all three windows are low, the field length (index 3) reads 525 and the interrupt half-line (index 1) reads 1023.
- R2: Each cycle with `line_end` high advances the position by 2, unless that step wraps. The new value is readable at index 2 from the next cycle. Without `line_end` the position holds.
- R3: When position + 2 is greater than or equal to the field length, a strobe wraps the position. If control bit 2 is clear, it wraps to 0.
- R4: With control bit 2 set, a wrap loads 1 when the old position was even and 0 when it was odd. Within a field the LSB does not change, and `field_id` equals that LSB.
- R5: `vint` goes high on the clock edge of a strobe whose new position equals the interrupt half-line at index 1. It stays high until it is acknowledged.
- R6: Any write to index 2 clears `vint` and leaves the position unchanged. If a write and a setting strobe fall on the same edge, the strobe wins and `vint` is high.
- R7: `vactive` is high while start <= position < end, with start and end taken from index 5. It is forced low while the pixel type (control bits [1:0]) is 0.
- R8: `burst_en` is high while start <= position < end, with start and end taken from index 6. It is forced low while the pixel type is 0.
- R9: `vsync` is high while the position is less than the sync width at index 4 bits [19:16]. It is forced low while the pixel type is 0.
- R10: Every register reads back only its defined fields, with all other bits 0. Index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_end | input | 1 | One-cycle strobe at each scan line end |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| vint | output | 1 | Pending vertical interrupt |
| vsync | output | 1 | Vertical sync window |
| vactive | output | 1 | Vertical active-video window |
| burst_en | output | 1 | Colour-burst enable window |
| field_id | output | 1 | Current field (position LSB) |

## Verification
The counter is driven with a field length of 7 in both progressive and interlaced modes. This separates a wrap to 0 from a wrap to 1, and shows whether the LSB stays fixed inside a field and flips between fields.

The interrupt is checked in three cases: on the first strobe that reaches the programmed half-line, while it stays pending, and when it is acknowledged. The acknowledge case includes a write that lands on the same edge as a setting strobe, which shows which of the two has priority.

The windows are stepped one position at a time across their edges, with different start and end values for each window. This catches swapped bounds, end-inclusive comparisons, and a wrong sync field position. A blanked pixel type is then applied over an active window to show the forcing.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
    localparam int CNT_W     = 10;
    localparam int SYNC_W    = 4;
    localparam int ADDR_W    = 3;
    localparam int START_LSB = 16;
    localparam int SYNC_LSB  = 16;
    localparam int ILACE_BIT = 2;
    localparam int TYPE_W    = 2;
    localparam int NUM_WIN   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_IRQ_LINE = 3'd1,
        REG_POS      = 3'd2,
        REG_FIELD    = 3'd3,
        REG_TIMING   = 3'd4,
        REG_ACTIVE   = 3'd5,
        REG_BURST    = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic [TYPE_W-1:0] pix_type;
        logic              ilace;
        logic [CNT_W-1:0]  irq_line;
        logic [CNT_W-1:0]  field_len;
        logic [SYNC_W-1:0] sync_w;
        logic [CNT_W-1:0]  act_lo;
        logic [CNT_W-1:0]  act_hi;
        logic [CNT_W-1:0]  brst_lo;
        logic [CNT_W-1:0]  brst_hi;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             irq;
    } cnt_st_t;
endpackage

// File: rtl/vlt_regs.sv
module vlt_regs
    import vlt_pkg::*;
#(
    parameter int               DATA_W        = 32,
    parameter logic [CNT_W-1:0] RST_FIELD_LEN = 10'd525,
    parameter logic [CNT_W-1:0] RST_IRQ_LINE  = 10'd1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  pos,
    output cfg_t              cfg,
    output logic              ack,
    output logic [DATA_W-1:0] bus_rdata
);
    cfg_t cfg_d, cfg_q;

    function automatic logic [DATA_W-1:0] pack_win(input logic [CNT_W-1:0] lo,
                                                   input logic [CNT_W-1:0] hi);
        pack_win = (DATA_W'(lo) << START_LSB) | DATA_W'(hi);
    endfunction

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we) begin
            case (bus_addr)
                REG_CTRL: begin
                    cfg_d.pix_type = bus_wdata[TYPE_W-1:0];
                    cfg_d.ilace    = bus_wdata[ILACE_BIT];
                end
                REG_IRQ_LINE: cfg_d.irq_line  = bus_wdata[CNT_W-1:0];
                REG_FIELD:    cfg_d.field_len = bus_wdata[CNT_W-1:0];
                REG_TIMING:   cfg_d.sync_w    = bus_wdata[SYNC_LSB +: SYNC_W];
                REG_ACTIVE: begin
                    cfg_d.act_lo = bus_wdata[START_LSB +: CNT_W];
                    cfg_d.act_hi = bus_wdata[CNT_W-1:0];
                end
                REG_BURST: begin
                    cfg_d.brst_lo = bus_wdata[START_LSB +: CNT_W];
                    cfg_d.brst_hi = bus_wdata[CNT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q           <= '0;
            cfg_q.field_len <= RST_FIELD_LEN;
            cfg_q.irq_line  <= RST_IRQ_LINE;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL:     bus_rdata = DATA_W'({cfg_q.ilace, cfg_q.pix_type});
            REG_IRQ_LINE: bus_rdata = DATA_W'(cfg_q.irq_line);
            REG_POS:      bus_rdata = DATA_W'(pos);
            REG_FIELD:    bus_rdata = DATA_W'(cfg_q.field_len);
            REG_TIMING:   bus_rdata = DATA_W'(cfg_q.sync_w) << SYNC_LSB;
            REG_ACTIVE:   bus_rdata = pack_win(cfg_q.act_lo, cfg_q.act_hi);
            REG_BURST:    bus_rdata = pack_win(cfg_q.brst_lo, cfg_q.brst_hi);
            default:      bus_rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
    assign ack = bus_we && (bus_addr == REG_POS);
endmodule

// File: rtl/vlt_counter.sv
module vlt_counter
    import vlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             ilace,
    input  logic [CNT_W-1:0] field_len,
    input  logic [CNT_W-1:0] irq_line,
    input  logic             ack,
    output logic [CNT_W-1:0] pos,
    output logic             irq
);
    cnt_st_t st_d, st_q;
    logic [CNT_W:0] step;

    always_comb begin
        st_d = st_q;
        step = {1'b0, st_q.pos} + (CNT_W+1)'(2);
        if (strobe) begin
            if (step >= {1'b0, field_len}) begin
                st_d.pos = ilace ? {{(CNT_W-1){1'b0}}, ~st_q.pos[0]} : '0;
            end else begin
                st_d.pos = step[CNT_W-1:0];
            end
        end
        if (ack) st_d.irq = 1'b0;
        if (strobe && (st_d.pos == irq_line)) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;
    assign irq = st_q.irq;
endmodule

// File: rtl/vlt_window.sv
module vlt_window #(
    parameter int W = 10
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] pos,
    input  logic         en,
    output logic         hit
);
    assign hit = en && (pos >= lo) && (pos < hi);
endmodule

// File: rtl/vline_timer.sv
module vline_timer
    import vlt_pkg::*;
#(
    parameter int               DATA_W        = 32,
    parameter logic [CNT_W-1:0] RST_FIELD_LEN = 10'd525,
    parameter logic [CNT_W-1:0] RST_IRQ_LINE  = 10'd1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              vint,
    output logic              vsync,
    output logic              vactive,
    output logic              burst_en,
    output logic              field_id
);
    cfg_t             cfg;
    logic             ack;
    logic [CNT_W-1:0] pos_w;
    logic             shown;
    logic [CNT_W-1:0] win_lo [NUM_WIN];
    logic [CNT_W-1:0] win_hi [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;

    vlt_regs #(
        .DATA_W(DATA_W), .RST_FIELD_LEN(RST_FIELD_LEN), .RST_IRQ_LINE(RST_IRQ_LINE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pos(pos_w), .cfg(cfg), .ack(ack), .bus_rdata(bus_rdata)
    );

    vlt_counter cnt_i (
        .clk(clk), .rst_n(rst_n), .strobe(line_end), .ilace(cfg.ilace),
        .field_len(cfg.field_len), .irq_line(cfg.irq_line), .ack(ack),
        .pos(pos_w), .irq(vint)
    );

    assign shown = (cfg.pix_type != '0);

    always_comb begin
        win_lo[0] = '0;
        win_hi[0] = CNT_W'(cfg.sync_w);
        win_lo[1] = cfg.act_lo;
        win_hi[1] = cfg.act_hi;
        win_lo[2] = cfg.brst_lo;
        win_hi[2] = cfg.brst_hi;
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        vlt_window #(.W(CNT_W)) win_i (
            .lo(win_lo[g]), .hi(win_hi[g]), .pos(pos_w), .en(shown), .hit(win_hit[g])
        );
    end

    assign vsync    = win_hit[0];
    assign vactive  = win_hit[1];
    assign burst_en = win_hit[2];
    assign field_id = pos_w[0];
endmodule

// File: rtl/vline_timer_chk.sv
module vline_timer_chk
    import vlt_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 line_end,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [CNT_W-1:0]     pos,
    input logic [CNT_W-1:0]     field_len,
    input logic                 ilace,
    input logic [TYPE_W-1:0]    pix_type,
    input logic                 vint,
    input logic                 vsync,
    input logic                 vactive,
    input logic                 burst_en,
    input logic                 field_id
);
    logic wraps;
    logic wr_pos;
    assign wraps  = ({1'b0, pos} + (CNT_W+1)'(2)) >= {1'b0, field_len};
    assign wr_pos = bus_we && (bus_addr == REG_POS);

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(pos)); // R2
    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && !wraps |=> pos == $past(pos) + CNT_W'(2)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && wraps && !ilace |=> pos == '0); // R3
    AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && wraps && ilace |=> pos == {{(CNT_W-1){1'b0}}, ~$past(pos[0])}); // R4
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        vint && !wr_pos |=> vint); // R5
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pos && !line_end |=> !vint); // R6
    AST_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        pix_type == '0 |-> !vsync && !vactive && !burst_en); // R7
    AST_FIELD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(field_id)); // R4
endmodule

bind vline_timer vline_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .bus_we(bus_we),
    .bus_addr(bus_addr), .pos(pos_w), .field_len(cfg.field_len),
    .ilace(cfg.ilace), .pix_type(cfg.pix_type), .vint(vint), .vsync(vsync),
    .vactive(vactive), .burst_en(burst_en), .field_id(field_id)
);

// File: tb/vline_timer_tb_top.sv
module vline_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_end = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vint, vsync, vactive, burst_en, field_id;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    vline_timer dut_i (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vint(vint), .vsync(vsync), .vactive(vactive), .burst_en(burst_en),
        .field_id(field_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_end = 1'b0;
        bus_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_end = 1'b1;
            @(negedge clk);
            line_end = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(3'd2, d); check("R1 position", d, 32'd0);
        check("R1 vint", {31'd0, vint}, 32'd0);
        check("R1 windows", {29'd0, vsync, vactive, burst_en}, 32'd0);
        rd(3'd3, d); check("R1 field length", d, 32'd525);
        rd(3'd1, d); check("R1 irq line", d, 32'd1023);
    endtask

    task automatic t_count();
        logic [31:0] d;
        do_reset();
        strobe(3);
        rd(3'd2, d); check("R2 three strobes", d, 32'd6);
        repeat (5) @(negedge clk);
        rd(3'd2, d); check("R2 hold without strobe", d, 32'd6);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        do_reset();
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R10 control", d, 32'h7);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); check("R10 irq line", d, 32'h3FF);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); check("R10 timing", d, 32'h000F_0000);
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, d); check("R10 active", d, 32'h03FF_03FF);
        wr(3'd6, 32'h1234_5678); rd(3'd6, d); check("R10 burst", d, 32'h0234_0278);
        rd(3'd7, d); check("R10 unused index", d, 32'h0);
    endtask

    task automatic t_wrap_plain();
        logic [31:0] d;
        do_reset();
        wr(3'd3, 32'd7);
        strobe(3);
        rd(3'd2, d); check("R3 before wrap", d, 32'd6);
        strobe(1);
        rd(3'd2, d); check("R3 wrap to zero", d, 32'd0);
        strobe(1);
        rd(3'd2, d); check("R3 next field", d, 32'd2);
    endtask

    task automatic t_wrap_ilace();
        logic [31:0] d;
        do_reset();
        wr(3'd0, 32'h4);
        wr(3'd3, 32'd7);
        strobe(4);
        rd(3'd2, d); check("R4 wrap to one", d, 32'd1);
        check("R4 field_id odd", {31'd0, field_id}, 32'd1);
        strobe(1);
        rd(3'd2, d); check("R4 odd field step", d, 32'd3);
        check("R4 lsb kept", {31'd0, field_id}, 32'd1);
        strobe(2);
        rd(3'd2, d); check("R4 wrap back to zero", d, 32'd0);
        check("R4 field_id even", {31'd0, field_id}, 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        do_reset();
        wr(3'd1, 32'd4);
        strobe(1);
        check("R5 not yet", {31'd0, vint}, 32'd0);
        strobe(1);
        check("R5 raised at match", {31'd0, vint}, 32'd1);
        strobe(1);
        check("R5 stays pending", {31'd0, vint}, 32'd1);
        wr(3'd2, 32'h55);
        check("R6 acknowledged", {31'd0, vint}, 32'd0);
        rd(3'd2, d); check("R6 position unchanged", d, 32'd6);
        wr(3'd1, 32'd8);
        @(negedge clk);
        line_end = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0;
        @(negedge clk);
        line_end = 1'b0; bus_we = 1'b0;
        check("R6 strobe beats ack", {31'd0, vint}, 32'd1);
    endtask

    task automatic t_windows();
        logic [2:0] exp [5];
        do_reset();
        wr(3'd0, 32'h2);
        wr(3'd4, 32'd3 << 16);
        wr(3'd5, (32'd4 << 16) | 32'd8);
        wr(3'd6, (32'd2 << 16) | 32'd6);
        exp[0] = 3'b100; exp[1] = 3'b101; exp[2] = 3'b011;
        exp[3] = 3'b010; exp[4] = 3'b000;
        for (int k = 0; k < 5; k++) begin
            check($sformatf("R9 vsync at %0d", 2*k), {31'd0, vsync}, {31'd0, exp[k][2]});
            check($sformatf("R7 vactive at %0d", 2*k), {31'd0, vactive}, {31'd0, exp[k][1]});
            check($sformatf("R8 burst_en at %0d", 2*k), {31'd0, burst_en}, {31'd0, exp[k][0]});
            if (k < 4) strobe(1);
        end
        wr(3'd5, 32'd20);
        wr(3'd6, 32'd20);
        check("R7 wide window shown", {31'd0, vactive}, 32'd1);
        wr(3'd0, 32'h0);
        check("R7 blanked vactive", {31'd0, vactive}, 32'd0);
        check("R8 blanked burst_en", {31'd0, burst_en}, 32'd0);
        wr(3'd4, 32'd15 << 16);
        check("R9 blanked vsync", {31'd0, vsync}, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_readback();
        t_wrap_plain();
        t_wrap_ilace();
        t_irq();
        t_windows();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule